// File: doc/BRIEF.md
# Halfword Permute Unit

The unit takes a 64-bit source word, treats it as four 16-bit lanes and builds a 64-bit result. Each result lane chooses any of the four source lanes, so one control byte can express a reversal, a broadcast, a shuffle or an interleave. A lane may be chosen more than once, and all 256 control values are legal.

The control byte holds four 2-bit selector fields. Field k sits in bits [2k+1:2k] and steers destination lane k. Lane 0 is bits [15:0] of both the source and the result.

The result and its valid strobe come from a single register stage. They appear one clock after the input is accepted. A synchronous active-high reset clears that stage.

Top module: `hwp_permute`

## Requirements
- R1: Result lane k (bits [16k+15:16k]) equals the source lane whose index is in control bits [2k+1:2k]. Lane 0 is bits [15:0].
- R2: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `out_data` carries that input's result.
- R3: While `rst` is high at a rising edge, `out_valid` and `out_data` both become zero after that edge.
- R4: When `in_valid` is low at a rising edge, `out_valid` is low after that edge and `out_data` keeps its previous value.
- R5: Control 0xE4 passes the source word through unchanged.
- R6: Control 0x1B reverses the lane order, so result lanes 0..3 come from source lanes 3, 2, 1 and 0.
- R7: Control 0xAA copies source lane 2 into all four result lanes. Control 0x00 copies source lane 0 into all four result lanes.
- R8: Control 0x8D gives result lanes 0..3 from source lanes 1, 3, 0 and 2. Control 0xD8 gives them from source lanes 0, 2, 1 and 3.
- R9: Every one of the 256 control values gives the result that R1 defines, including values that repeat a source lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source word and control are valid |
| in_data | input | 64 | Source word, four 16-bit lanes |
| in_ctrl | input | 8 | Four 2-bit lane selectors, little-endian |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 64 | Registered permuted word |

## Verification
The bench builds the unit with its default parameters: four lanes of 16 bits and an 8-bit control. At that size, an exhaustive sweep of every control value is small enough to run. The sweep uses random source words, so each lane selector is exercised against distinct lane contents. Random runs with gaps in `in_valid` check the output hold. A reset applied in the middle of a run checks the clear.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  localparam int HWP_LANE_W = 16;
  localparam int HWP_LANES  = 4;
endpackage

// File: rtl/hwp_lane_mux.sv
module hwp_lane_mux #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int SEL_W  = 2
) (
  input  logic [LANES*LANE_W-1:0] src,
  input  logic [SEL_W-1:0]        sel,
  output logic [LANE_W-1:0]       lane
);
  always_comb begin
    lane = '0;
    for (int i = 0; i < LANES; i++) begin
      if (sel == SEL_W'(i)) lane = src[i*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/hwp_xbar.sv
module hwp_xbar #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int SEL_W  = 2
) (
  input  logic [LANES*LANE_W-1:0] src,
  input  logic [LANES*SEL_W-1:0]  ctrl,
  output logic [LANES*LANE_W-1:0] dst
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    hwp_lane_mux #(.LANE_W(LANE_W), .LANES(LANES), .SEL_W(SEL_W)) u_mux (
      .src  (src),
      .sel  (ctrl[k*SEL_W +: SEL_W]),
      .lane (dst[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/hwp_out_reg.sv
module hwp_out_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) q <= d;
    end
  end
endmodule

// File: rtl/hwp_permute.sv
module hwp_permute #(
  parameter int LANE_W = hwp_pkg::HWP_LANE_W,
  parameter int LANES  = hwp_pkg::HWP_LANES,
  localparam int SEL_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W,
  localparam int CTRL_W = LANES * SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] perm;

  hwp_xbar #(.LANE_W(LANE_W), .LANES(LANES), .SEL_W(SEL_W)) u_xbar (
    .src  (in_data),
    .ctrl (in_ctrl),
    .dst  (perm)
  );

  hwp_out_reg #(.W(DATA_W)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d       (perm),
    .q_valid (out_valid),
    .q       (out_data)
  );
endmodule

// File: rtl/hwp_permute_chk.sv
module hwp_permute_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int SEL_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W,
  localparam int CTRL_W = LANES * SEL_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [CTRL_W-1:0] in_ctrl,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  function automatic logic [CTRL_W-1:0] ident_ctrl();
    logic [CTRL_W-1:0] c;
    c = '0;
    for (int k = 0; k < LANES; k++) c[k*SEL_W +: SEL_W] = SEL_W'(k);
    return c;
  endfunction

  localparam logic [CTRL_W-1:0] IDENT = ident_ctrl();

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0)); // R3

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data)); // R4

  AST_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ctrl == IDENT) |=> (out_data == $past(in_data))); // R5

  AST_BCAST_LANE0: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ctrl == '0) |=>
      (out_data == {LANES{$past(in_data[LANE_W-1:0])}})); // R7
endmodule

bind hwp_permute hwp_permute_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ctrl   (in_ctrl),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_hwp_permute.sv
`timescale 1ns/1ps
module tb_hwp_permute;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [63:0] held = '0;

  always #4 clk = ~clk;

  hwp_permute dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ctrl(in_ctrl), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] model(input logic [63:0] s, input logic [7:0] c);
    logic [63:0] r;
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = int'(c[2*k +: 2]);
      r[16*k +: 16] = s[16*idx +: 16];
    end
    return r;
  endfunction

  function automatic logic [63:0] lanes(input logic [15:0] l3, l2, l1, l0);
    return {l3, l2, l1, l0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [63:0] d, input logic [7:0] c,
                      input logic [63:0] exp, input string req);
    @(negedge clk);
    in_valid = v; in_data = d; in_ctrl = c;
    @(posedge clk); #1;
    if (v) begin
      chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
      chk(req, out_data, exp);
      held = exp;
    end else begin
      chk({req, " valid low"}, {63'd0, out_valid}, 64'd0);
      chk({req, " hold"}, out_data, held);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    logic [63:0] s;
    void'($urandom(32'h1234_5678));
    s = 64'h4444_3333_2222_1111;
    repeat (2) @(posedge clk);
    #1;
    chk("R3 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R3 reset data", out_data, 64'd0);
    @(negedge clk); rst = 1'b0;

    step(1, s, 8'hE4, s, "R5 identity");
    step(1, s, 8'h1B, lanes(16'h1111, 16'h2222, 16'h3333, 16'h4444), "R6 reverse");
    step(1, s, 8'hAA, {4{16'h3333}}, "R7 bcast lane2");
    step(1, s, 8'h00, {4{16'h1111}}, "R7 bcast lane0");
    step(1, s, 8'h8D, lanes(16'h3333, 16'h1111, 16'h4444, 16'h2222), "R8 shuffle 8D");
    step(1, s, 8'hD8, lanes(16'h4444, 16'h2222, 16'h3333, 16'h1111), "R8 alternate D8");
    step(0, rnd64(), 8'h1B, 64'd0, "R4 idle");
    step(0, rnd64(), 8'h55, 64'd0, "R4 idle again");
    step(1, s, 8'hFF, {4{16'h4444}}, "R1 bcast lane3");

    for (int c = 0; c < 256; c++) begin
      logic [63:0] d;
      d = rnd64();
      step(1, d, 8'(c), model(d, 8'(c)), "R9 sweep");
    end

    for (int i = 0; i < 600; i++) begin
      logic [63:0] d;
      logic [7:0]  c;
      logic        v;
      d = rnd64(); c = 8'($urandom()); v = ($urandom() % 4) != 0;
      step(v, d, c, model(d, c), "R1 random");
      if (i == 300) begin
        @(negedge clk); rst = 1'b1; in_valid = 1'b1;
        @(posedge clk); #1;
        chk("R3 mid reset valid", {63'd0, out_valid}, 64'd0);
        chk("R3 mid reset data", out_data, 64'd0);
        held = '0;
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
      end
    end

    step(1, s, 8'hE4, s, "R2 final");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule